// File: doc/BRIEF.md
# Multiprocessor Interrupt Source Distributor

This block gathers a configurable number of level-sensitive interrupt inputs and decides, for each one, which processors see it. Each source has a global enable and a routing bitmap with one bit per processor. A source is pending at processor `c` for as long as three conditions hold together: its input is high, its enable is set, and bit `c` of its bitmap is set. The pending vectors for all processors go to the acknowledge logic of each processor.

Software reaches the block over a simple bus. A write completes in one cycle and a read returns data in the same cycle. A source's enable is changed by writing the source number to a set port or to a clear port, so no read-modify-write is needed. Each source has its own routing word. A read-only control word reports how many sources are implemented. The hardware does not stop two processors from taking the same source: a bitmap may hold several bits, and the block keeps no ownership state.

Top module: `irqd_top`

## Requirements
- R1: After reset every enable is clear and every routing bitmap is zero. All of `pend_o` is therefore low even when all inputs are high, and every routing word reads as zero.
- R2: A read of offset 0x000 returns the number of implemented sources in bits [11:2], with all other bits zero. With the default of 32 sources this value is 0x80.
- R3: A write of source number `s` to offset 0x030 sets the enable of source `s` at the next clock edge.
- R4: A write of source number `s` to offset 0x034 clears the enable of source `s` at the next clock edge.
- R5: A set or clear write whose full 32-bit data value is greater than or equal to the number of sources changes no enable. This includes values that alias a valid source in their low bits.
- R6: The routing word of source `s` sits at offset 0x100 + 4*s. Its bit `c` routes the source to processor `c`. A write stores the low N_CPU bits of the data, and a read returns the stored bitmap with all upper bits zero.
- R7: Bit `c*N_SRC + s` of `pend_o` equals the input of source `s` AND the enable of source `s` AND routing bit `c` of source `s`. It follows the input level in the same cycle.
- R8: A source routed to several processors is pending at all of them at the same time.
- R9: Writes to the control word at offset 0x000 have no effect: its read value, the enables and the routing stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | N_SRC | Level interrupt inputs |
| bus_req_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte offset |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, valid in the cycle of the request |
| pend_o | output | N_CPU*N_SRC | Pending vector per processor; bit c*N_SRC+s |

## Verification
A write of an enable or a routing word takes effect at the clock edge that samples the request. Its effect on `pend_o` is therefore visible from that edge on. Reads of the control and routing words are combinational, and so is the path from `src_i` to `pend_o`. The bench drives every request at a falling edge and checks writes at the next falling edge, after exactly one rising edge. Reads and input-level changes are checked within the same low phase, a short delay after the stimulus.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  localparam int unsigned OFF_CTRL   = 32'h000;
  localparam int unsigned OFF_EN_SET = 32'h030;
  localparam int unsigned OFF_EN_CLR = 32'h034;
  localparam int unsigned OFF_ROUTE  = 32'h100;
  localparam int unsigned CNT_LSB    = 2;
  localparam int unsigned CNT_W      = 10;
endpackage

// File: rtl/irqd_enable.sv
module irqd_enable #(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_v_i,
  input  logic              clr_v_i,
  input  logic [DATA_W-1:0] idx_i,
  output logic [N_SRC-1:0]  en_o
);
  logic [N_SRC-1:0] en_q;
  logic             in_rng;
  logic [IDX_W-1:0] sel;

  // full-width compare so aliased high indices are dropped
  assign in_rng = idx_i < DATA_W'(N_SRC);
  assign sel    = idx_i[IDX_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 en_q <= '0;
    else if (set_v_i && in_rng)  en_q[sel] <= 1'b1;
    else if (clr_v_i && in_rng)  en_q[sel] <= 1'b0;
  end

  assign en_o = en_q;

  assert_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_v_i && in_rng) |=> en_o[$past(sel)]);

  assert_clr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_v_i && !set_v_i && in_rng) |=> !en_o[$past(sel)]);

  assert_ignore_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((set_v_i || clr_v_i) && !in_rng) |=> $stable(en_o));
endmodule

// File: rtl/irqd_route.sv
module irqd_route #(
  parameter int unsigned N_SRC = 32,
  parameter int unsigned N_CPU = 4,
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_v_i,
  input  logic [IDX_W-1:0]       idx_i,
  input  logic [N_CPU-1:0]       map_i,
  input  logic [N_SRC-1:0]       src_i,
  input  logic [N_SRC-1:0]       en_i,
  output logic [N_CPU-1:0]       map_o,
  output logic [N_CPU*N_SRC-1:0] pend_o
);
  logic [N_CPU-1:0] map_q [N_SRC];

  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             map_q[s] <= '0;
      else if (wr_v_i && idx_i == IDX_W'(s))   map_q[s] <= map_i;
    end
    for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
      assign pend_o[c*N_SRC+s] = src_i[s] & en_i[s] & map_q[s][c];
    end
  end

  assign map_o = map_q[idx_i];

  assert_wr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_v_i |=> (map_q[$past(idx_i)] == $past(map_i)));
endmodule

// File: rtl/irqd_top.sv
module irqd_top
  import irqd_pkg::*;
#(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned N_CPU  = 4,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_SRC-1:0]       src_i,
  input  logic                   bus_req_i,
  input  logic                   bus_we_i,
  input  logic [ADDR_W-1:0]      bus_addr_i,
  input  logic [DATA_W-1:0]      bus_wdata_i,
  output logic [DATA_W-1:0]      bus_rdata_o,
  output logic [N_CPU*N_SRC-1:0] pend_o
);
  logic              wr, rd;
  logic              set_v, clr_v, rt_hit;
  logic [ADDR_W-1:0] rt_off, rt_word;
  logic [N_SRC-1:0]  en;
  logic [N_CPU-1:0]  rd_map;

  assign wr      = bus_req_i & bus_we_i;
  assign rd      = bus_req_i & ~bus_we_i;
  assign set_v   = wr && (bus_addr_i == ADDR_W'(OFF_EN_SET));
  assign clr_v   = wr && (bus_addr_i == ADDR_W'(OFF_EN_CLR));
  assign rt_off  = bus_addr_i - ADDR_W'(OFF_ROUTE);
  assign rt_word = rt_off >> 2;
  assign rt_hit  = (bus_addr_i >= ADDR_W'(OFF_ROUTE)) && (bus_addr_i[1:0] == 2'b00)
                   && (rt_word < ADDR_W'(N_SRC));

  irqd_enable #(.N_SRC(N_SRC), .DATA_W(DATA_W)) u_enable (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_v_i (set_v),
    .clr_v_i (clr_v),
    .idx_i   (bus_wdata_i),
    .en_o    (en)
  );

  irqd_route #(.N_SRC(N_SRC), .N_CPU(N_CPU)) u_route (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_v_i  (wr && rt_hit),
    .idx_i   (rt_word[IDX_W-1:0]),
    .map_i   (bus_wdata_i[N_CPU-1:0]),
    .src_i   (src_i),
    .en_i    (en),
    .map_o   (rd_map),
    .pend_o  (pend_o)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (rd) begin
      if (bus_addr_i == ADDR_W'(OFF_CTRL))
        bus_rdata_o[CNT_LSB +: CNT_W] = CNT_W'(N_SRC);
      else if (rt_hit)
        bus_rdata_o[N_CPU-1:0] = rd_map;
    end
  end

  assert_level_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o & ~{N_CPU{src_i & en}}) == '0);
endmodule

// File: tb/tb_irqd_top.sv
module tb_irqd_top;
  localparam int NS = 32;
  localparam int NC = 4;
  localparam int AW = 12;
  localparam int DW = 32;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NS-1:0] src = '0;
  logic req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [NC*NS-1:0] pend;

  int checks = 0, errors = 0;
  logic [NS-1:0] en_m = '0;
  logic [NC-1:0] rt_m [NS];

  always #(CLK_PERIOD/2) clk = ~clk;

  irqd_top #(.N_SRC(NS), .N_CPU(NC), .ADDR_W(AW), .DATA_W(DW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src),
    .bus_req_i(req), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .pend_o(pend)
  );

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_pend(string tag);
    logic [NC*NS-1:0] e;
    for (int c = 0; c < NC; c++)
      for (int s = 0; s < NS; s++)
        e[c*NS+s] = src[s] & en_m[s] & rt_m[s][c];
    checks++;
    if (pend !== e) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, pend, e);
    end
  endtask

  task automatic bus_wr(int a, logic [DW-1:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(int a, output logic [DW-1:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = AW'(a);
    #1 d = rdata;
    req = 1'b0;
  endtask

  task automatic set_src(logic [NS-1:0] v);
    @(negedge clk);
    src = v;
    #1;
  endtask

  task automatic t_reset();
    logic [DW-1:0] d;
    set_src('1);
    chk_pend("R1 pend after reset");
    bus_rd(32'h100, d);          chk("R1 route0 reset", d, 0);
    bus_rd(32'h100 + 4*17, d);   chk("R1 route17 reset", d, 0);
    bus_rd(32'h100 + 4*(NS-1), d); chk("R1 route last reset", d, 0);
  endtask

  task automatic t_ctrl();
    logic [DW-1:0] d;
    bus_rd(32'h000, d); chk("R2 ctrl count", d, DW'(NS) << 2);
    bus_wr(32'h000, '1);
    bus_rd(32'h000, d); chk("R9 ctrl after write", d, DW'(NS) << 2);
    chk_pend("R9 pend after ctrl write");
  endtask

  task automatic t_enable();
    bus_wr(32'h100 + 4*3, 32'h1); rt_m[3] = 4'h1;
    bus_wr(32'h030, 3);           en_m[3] = 1'b1;
    chk_pend("R3 set enable 3");
    chk("R3 pend bit 3", DW'(pend[3]), 1);
    bus_wr(32'h030, 7);           en_m[7] = 1'b1;
    chk_pend("R7 enabled but unrouted 7");
    bus_wr(32'h034, 3);           en_m[3] = 1'b0;
    chk_pend("R4 clear enable 3");
  endtask

  task automatic t_range();
    bus_wr(32'h100 + 4*5, 32'h2); rt_m[5] = 4'h2;
    bus_wr(32'h030, 5);           en_m[5] = 1'b1;
    chk_pend("R3 set enable 5");
    bus_wr(32'h034, NS + 5);
    chk_pend("R5 clear alias index ignored");
    bus_wr(32'h030, NS);
    bus_wr(32'h030, 32'hFFFF_FFFF);
    bus_wr(32'h100 + 4*2, 32'h4); rt_m[2] = 4'h4;
    bus_wr(32'h030, 32'h0001_0002);
    chk_pend("R5 set out of range ignored");
  endtask

  task automatic t_route();
    logic [DW-1:0] d;
    bus_wr(32'h100 + 4*10, 32'hFFFF_FFFF); rt_m[10] = '1;
    bus_rd(32'h100 + 4*10, d); chk("R6 route10 upper bits zero", d, 32'hF);
    bus_wr(32'h100 + 4*(NS-1), 32'h8); rt_m[NS-1] = 4'h8;
    bus_rd(32'h100 + 4*(NS-1), d); chk("R6 route last", d, 32'h8);
    bus_rd(32'h100 + 4*5, d); chk("R6 route5 kept", d, 32'h2);
  endtask

  task automatic t_multi();
    bus_wr(32'h030, 10); en_m[10] = 1'b1;
    bus_wr(32'h030, NS-1); en_m[NS-1] = 1'b1;
    chk_pend("R8 multi-cpu routed");
    for (int c = 0; c < NC; c++)
      chk("R8 src10 at each cpu", DW'(pend[c*NS+10]), 1);
    set_src(~(NS'(1) << 10));
    chk_pend("R7 level drop src10");
    set_src(NS'(32'hA5A5_0F0F));
    chk_pend("R7 pattern");
    set_src('1);
    chk_pend("R7 all high");
  endtask

  initial begin
    for (int s = 0; s < NS; s++) rt_m[s] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ctrl();
    t_enable();
    t_range();
    t_route();
    t_multi();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule